// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block sits on the processor side of a 32-bit data bus. It accepts one operand transfer at a time: a start address, an operand length of one to four bytes, a direction and (for writes) the operand itself. It carries out the transfer as one or more bus cycles. The responder that answers a cycle does not need to be known in advance. It reports its own port width (8, 16 or 32 bits) with its acknowledge. The sequencer uses that width to work out how many bytes the cycle moved. It then advances the address, shrinks the remaining count and issues further cycles until the whole operand has crossed the bus.

Every cycle carries the full address and a 2-bit code for the bytes still outstanding. A responder can therefore pick the lanes it should act on. On writes the sequencer places the outstanding bytes on the data lanes so that a port of any width finds the bytes meant for it. On reads it collects the bytes each port returns from the lanes that port uses. It assembles them into a right-justified operand, which it presents with a one-cycle completion pulse.

Operands are big-endian. The byte at the lowest address is the most significant byte of the operand. An operand of N bytes occupies bits 8N-1:0 of the request data and of the completed read data.

Top module: `dbs_seq`

## Requirements
- R1: After reset `bus_cyc`, `busy` and `done` are low.
- R2: With the sequencer idle, a request accepted on `req_valid` opens a bus cycle on the next clock. That cycle carries `bus_addr` equal to `req_addr` and `bus_siz` equal to the length code `req_len`. The length code is 01 for one byte, 10 for two bytes, 11 for three bytes and 00 for four bytes. `bus_write` follows `req_write`.
- R3: The acknowledge `bus_ack` is decoded as follows: 01 is an 8-bit port, 10 is a 16-bit port and 11 is a 32-bit port. Each acknowledged cycle moves the bytes from the current address up to the end of that port's naturally aligned block, but no more than the bytes outstanding. The next cycle's address is higher by that count, and its `bus_siz` codes what is still outstanding. For a port of W bytes, an operand of N bytes at address offset a (mod 4) needs floor((a+N-1)/W) - floor(a/W) + 1 cycles.
- R4: While `bus_ack` is 00 the cycle is held: `bus_cyc`, `bus_addr` and `bus_siz` keep their values.
- R5: On writes the outstanding bytes sit where each port width expects them. An 8-bit port uses lane D31:24. A 16-bit port uses D31:16, with the even-address byte on D31:24. A 32-bit port uses the lane picked by address bits 1:0, with offset 0 on D31:24. Every written byte lands at its own address, and bytes outside the operand are left untouched.
- R6: A cycle with one byte outstanding drives that byte on all four lanes. A cycle with two bytes outstanding at an even address drives the same 16 bits on D31:16 and on D15:0.
- R7: On reads the completed operand holds the bytes at the operand's addresses in big-endian order, right-justified in `done_rdata`. Bytes on lanes the answering port does not use are not taken into the operand.
- R8: The clock after the final acknowledge, `done` is high for exactly one cycle, and `bus_cyc` and `busy` are low.
- R9: `req_valid` is ignored while a transfer is in progress. The transfer's addresses and data are unchanged, and no further cycle starts after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a transfer (taken only while idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address of the first operand byte |
| req_len | input | 2 | Operand length code (01/10/11/00 = 1/2/3/4 bytes) |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | Transfer in progress |
| bus_cyc | output | 1 | Bus cycle active |
| bus_write | output | 1 | Direction of the active cycle |
| bus_addr | output | ADDR_W | Address of the first outstanding byte |
| bus_siz | output | 2 | Outstanding byte count code |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes |
| bus_ack | input | 2 | Acknowledge with port width; 00 = wait |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Assembled read operand |

## Verification
The assertions check, on every cycle, the properties that do not depend on the responder's memory. A waiting cycle must hold its address and count. Each acknowledge short of the last must move the address forward. The completion pulse must follow the last acknowledge and last only one cycle. Byte and aligned-word writes must replicate across the lanes. Whether each port width finds the right bytes, whether untouched neighbours survive, whether read bytes come back in the right order and whether the cycle count matches the block arithmetic only show up in the bench's sweep. That sweep runs every length, offset, direction and port width against a byte-addressed responder model, with wait states and stray requests mixed in.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;

  // Port width in bytes from the acknowledge code; 0 means wait.
  function automatic logic [2:0] port_bytes(input logic [1:0] ack);
    case (ack)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Outstanding bytes from a length code (00 stands for four).
  function automatic logic [2:0] rem_of_code(input logic [1:0] c);
    return (c == 2'b00) ? 3'd4 : {1'b0, c};
  endfunction

  // Byte position inside the port's aligned block.
  function automatic logic [1:0] lane_offset(input logic [1:0] a, input logic [2:0] pw);
    if (pw == 3'd4) return a;
    if (pw == 3'd2) return {1'b0, a[0]};
    return 2'b00;
  endfunction

  // Bytes one acknowledged cycle moves.
  function automatic logic [2:0] bytes_moved(input logic [1:0] a, input logic [2:0] rem,
                                             input logic [2:0] pw);
    logic [2:0] span;
    span = pw - {1'b0, lane_offset(a, pw)};
    return (rem < span) ? rem : span;
  endfunction

  // Which outstanding byte drives write lane p (p = 0 is D31:24).
  function automatic logic [1:0] lane_src(input logic [1:0] p, input logic [1:0] a,
                                          input logic [2:0] rem);
    logic [2:0] k;
    if (rem == 3'd0) return 2'b00;
    if (p >= a)         k = {1'b0, p - a};
    else if (a == 2'd2) k = {1'b0, p};
    else                k = 3'd0;
    k = k % rem;
    return k[1:0];
  endfunction

endpackage

// File: rtl/dbs_wlane.sv
module dbs_wlane
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] out_bytes,  // outstanding bytes, first at top
  input  logic [1:0]        offs,
  input  logic [2:0]        rem,
  output logic [DATA_W-1:0] lanes
);

  logic [1:0] src [LANES];

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign src[p] = lane_src(2'(p), offs, rem);
    assign lanes[DATA_W-1-BYTE_W*p -: BYTE_W] =
      out_bytes[DATA_W-1-BYTE_W*int'(src[p]) -: BYTE_W];
  end

endmodule

// File: rtl/dbs_rmerge.sv
module dbs_rmerge
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        offs,
  input  logic [2:0]        pw,
  input  logic [2:0]        moved,
  input  logic [DATA_W-1:0] acc_in,
  output logic [DATA_W-1:0] acc_out
);

  logic [1:0]        first_lane;
  logic [DATA_W-1:0] top_aligned;
  logic [DATA_W-1:0] fresh;

  always_comb begin
    first_lane  = lane_offset(offs, pw);
    top_aligned = rdata << {first_lane, 3'b000};
    fresh       = top_aligned >> {(3'd4 - moved), 3'b000};
    acc_out     = (acc_in << {moved, 3'b000}) | fresh;
  end

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              bus_cyc,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        bus_ack,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata
);

  logic              run_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic [DATA_W-1:0] wq_q;
  logic [DATA_W-1:0] acc_q;
  logic              done_q;
  logic [DATA_W-1:0] done_data_q;

  // Named internal events
  logic              start_evt;
  logic              ack_seen;
  logic              final_ack;
  logic [2:0]        pw;
  logic [2:0]        moved;
  logic [2:0]        req_bytes;
  logic [DATA_W-1:0] acc_next;
  logic [DATA_W-1:0] lane_data;

  assign start_evt = req_valid && !run_q;
  assign pw        = port_bytes(bus_ack);
  assign ack_seen  = run_q && (pw != 3'd0);
  assign moved     = bytes_moved(addr_q[1:0], rem_q, pw);
  assign final_ack = ack_seen && (moved == rem_q);
  assign req_bytes = rem_of_code(req_len);

  dbs_wlane u_wlane (
    .out_bytes (wq_q),
    .offs      (addr_q[1:0]),
    .rem       (rem_q),
    .lanes     (lane_data)
  );

  dbs_rmerge u_rmerge (
    .rdata   (bus_rdata),
    .offs    (addr_q[1:0]),
    .pw      (pw),
    .moved   (moved),
    .acc_in  (acc_q),
    .acc_out (acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      rem_q       <= 3'd4;
      wq_q        <= '0;
      acc_q       <= '0;
      done_q      <= 1'b0;
      done_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_evt) begin
        run_q  <= 1'b1;
        wr_q   <= req_write;
        addr_q <= req_addr;
        rem_q  <= req_bytes;
        wq_q   <= req_wdata << {(3'd4 - req_bytes), 3'b000};
        acc_q  <= '0;
      end else if (ack_seen) begin
        addr_q <= addr_q + ADDR_W'(moved);
        rem_q  <= rem_q - moved;
        wq_q   <= wq_q << {moved, 3'b000};
        acc_q  <= acc_next;
        if (final_ack) begin
          run_q       <= 1'b0;
          rem_q       <= 3'd4;
          done_q      <= 1'b1;
          done_data_q <= acc_next;
        end
      end
    end
  end

  assign busy       = run_q;
  assign bus_cyc    = run_q;
  assign bus_write  = wr_q;
  assign bus_addr   = addr_q;
  assign bus_siz    = rem_q[1:0];
  assign bus_wdata  = lane_data;
  assign done       = done_q;
  assign done_rdata = done_data_q;

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_ack == 2'b00) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz)));

  // R3
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_seen && !final_ack) |=> (bus_cyc && bus_addr != $past(bus_addr)
                                  && bus_siz != $past(bus_siz)));

  // R8
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_ack |=> (done && !bus_cyc && !busy));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_write && bus_siz == 2'b01) |->
      (bus_wdata[31:24] == bus_wdata[23:16] && bus_wdata[23:16] == bus_wdata[15:8]
       && bus_wdata[15:8] == bus_wdata[7:0]));

  // R6
  word_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_write && bus_siz == 2'b10 && !bus_addr[0]) |->
      (bus_wdata[31:16] == bus_wdata[15:0]));

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (bus_cyc && bus_addr == $past(req_addr)
                              && bus_siz == $past(req_len)));

endmodule

// File: tb/dbs_seq_tb.sv
`timescale 1ns/1ps
module dbs_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, bus_cyc, bus_write, done;
  logic [31:0] bus_addr, bus_wdata, done_rdata;
  logic [1:0]  bus_siz;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_ack;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbs_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .bus_cyc(bus_cyc), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done), .done_rdata(done_rdata)
  );

  // Responder model: byte memory, port width, wait states
  logic [7:0] mem [32];
  int   port_w   = 4;
  int   wait_tgt = 0;
  int   wcnt     = 0;
  int   acks     = 0;
  bit   load_go  = 0;
  int   seed     = 0;

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 29) ^ (s * 7) ^ 8'hA5);
  endfunction

  function automatic logic [1:0] ack_code(int w);
    return (w == 1) ? 2'b01 : (w == 2) ? 2'b10 : 2'b11;
  endfunction

  always_comb begin
    int b;
    b = int'(bus_addr[4:0]);
    bus_ack   = 2'b00;
    bus_rdata = 32'hEEEE_EEEE;
    if (bus_cyc && wcnt >= wait_tgt) bus_ack = ack_code(port_w);
    if (port_w == 1)      bus_rdata = {mem[b], 24'hEEEEEE};
    else if (port_w == 2) bus_rdata = {mem[b & ~1], mem[b | 1], 16'hEEEE};
    else                  bus_rdata = {mem[b & ~3], mem[(b & ~3) + 1],
                                       mem[(b & ~3) + 2], mem[(b & ~3) + 3]};
  end

  always @(posedge clk) begin
    if (load_go) begin
      for (int i = 0; i < 32; i++) mem[i] <= pat(i, seed);
    end else if (bus_cyc && bus_ack != 2'b00) begin
      acks <= acks + 1;
      wcnt <= 0;
      if (bus_write) begin
        int a, off, rem;
        a   = int'(bus_addr[4:0]);
        off = a & (port_w - 1);
        rem = (bus_siz == 2'b00) ? 4 : int'(bus_siz);
        for (int j = 0; j < 4; j++)
          if (j < rem && off + j < port_w)
            mem[(a + j) % 32] <= bus_wdata[31 - 8*(off + j) -: 8];
      end
    end else if (bus_cyc) begin
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Wait-state monitor (R4)
  bit        prev_wait = 0;
  logic [31:0] prev_addr;
  logic [1:0]  prev_siz;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait)
        chk(bus_cyc && bus_addr == prev_addr && bus_siz == prev_siz, "R4",
            "held cycle changed", bus_addr, prev_addr);
      prev_wait = bus_cyc && (bus_ack == 2'b00);
      prev_addr = bus_addr;
      prev_siz  = bus_siz;
    end
  end

  task automatic transfer(int idx, bit wr, int w, int a, int n, int waits, bit inject);
    logic [31:0] wd, exp_rd;
    logic [7:0]  exp_mem [32];
    int base, acks0, tmo, exp_cyc;
    base = 8 + a;
    wd = {8'(idx), 8'(~idx), 8'(idx ^ 8'h5A), 8'(8'hC3 ^ idx)};
    // preload memory
    @(negedge clk);
    seed = idx; port_w = w; wait_tgt = waits; load_go = 1;
    @(negedge clk);
    load_go = 0;
    for (int i = 0; i < 32; i++) exp_mem[i] = pat(i, idx);
    exp_rd = '0;
    for (int k = 0; k < n; k++) begin
      exp_rd = (exp_rd << 8) | 32'(exp_mem[base + k]);
      if (wr) exp_mem[base + k] = wd[8*(n-1-k) +: 8];
    end
    acks0 = acks;
    req_valid = 1; req_write = wr; req_addr = 32'(base);
    req_len = 2'(n); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    // R2 first cycle
    chk(bus_cyc && bus_addr == 32'(base) && bus_siz == 2'(n) && bus_write == wr, "R2",
        "first cycle addr/siz", {bus_cyc, 21'd0, bus_siz, bus_addr[7:0]},
        {1'b1, 21'd0, 2'(n), 8'(base)});
    if (wr && n == 1)
      chk(bus_wdata == {4{wd[7:0]}}, "R6", "byte on all lanes", bus_wdata, {4{wd[7:0]}});
    if (wr && n == 2 && (a % 2) == 0)
      chk(bus_wdata == {2{wd[15:0]}}, "R6", "word duplicated", bus_wdata, {2{wd[15:0]}});
    if (inject) begin
      req_valid = 1; req_addr = 32'(base ^ 5); req_len = 2'b00; req_write = ~wr;
      @(negedge clk);
      req_valid = 0;
    end
    tmo = 0;
    while (!done && tmo < 100) begin @(negedge clk); tmo++; end
    chk(done == 1'b1, "R8", "done pulse seen", 32'(done), 32'd1);
    chk(!bus_cyc && !busy, "R8", "bus idle at done", {30'd0, bus_cyc, busy}, 32'd0);
    exp_cyc = (a + n - 1) / w - a / w + 1;
    chk(acks - acks0 == exp_cyc, "R3", "cycle count", 32'(acks - acks0), 32'(exp_cyc));
    if (wr) begin
      bit ok = 1;
      int bad = 0;
      for (int i = 0; i < 32; i++) if (mem[i] != exp_mem[i]) begin ok = 0; bad = i; end
      chk(ok, "R5", "memory after write", {24'd0, mem[bad]}, {24'd0, exp_mem[bad]});
    end else begin
      chk(done_rdata == exp_rd, "R7", "read operand", done_rdata, exp_rd);
    end
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", 32'(done), 32'd0);
    if (inject)
      chk(!bus_cyc && !busy, "R9", "stray request started cycle",
          {30'd0, bus_cyc, busy}, 32'd0);
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_cyc && !busy && !done, "R1", "reset outputs", {29'd0, bus_cyc, busy, done}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int wi = 0; wi < 3; wi++)
      for (int n = 1; n <= 4; n++)
        for (int a = 0; a < 4; a++)
          for (int wr = 0; wr < 2; wr++) begin
            transfer(idx, wr[0], 1 << wi, a, n, idx % 3, (idx % 5) == 0);
            idx++;
          end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule